// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block is the software-visible register file of a 64-channel DMA engine. It sits on a simple 32-bit register bus and keeps four per-channel bitmaps: request enable, error-interrupt enable, interrupt pending and error pending. It also keeps a per-channel done bitmap. Each bitmap is 64 bits wide. It is read and written as a low word for channels 31..0 and a high word for channels 63..32.

Software can rewrite whole words. It can also write a single channel number to a command register, which sets or clears that one channel's bit without a read-modify-write. The transfer engine reports completions and errors on per-channel strobes, and the block turns these into pending bits and two interrupt lines.

A global error status word captures the channel and the cause of the first error. It holds them until software clears it. A control word carries the arbitration mode bits to the engine.

Top module: `dmacsr_top`

## Requirements
- R1: After reset, every bitmap, the control word and the error status word are zero, `start_pulse` is zero, and `done_irq`, `err_irq` and `bus_rvalid` are low.
- R2: A read is issued by asserting `bus_rd`. `bus_rvalid` is high in the following cycle with the addressed register in `bus_rdata`. Command registers and unmapped addresses read as zero. The byte offsets are:
  - 0x00 control
  - 0x04 error status
  - 0x08/0x0C request enable low/high
  - 0x10/0x14 error-interrupt enable low/high
  - 0x18/0x1C interrupt pending low/high
  - 0x20/0x24 error pending low/high
  - 0x28/0x2C done low/high
  - 0x30 set request
  - 0x34 clear request
  - 0x38 set error-interrupt enable
  - 0x3C clear error-interrupt enable
  - 0x40 clear interrupt
  - 0x44 clear error
  - 0x48 start
  - 0x4C clear done
- R3: Channel c lives in bit c of the low word when c < 32, and in bit c-32 of the high word otherwise. Writing c to the set-request or clear-request register sets or clears request-enable bit c. A full-word write to a request-enable word replaces that word. `req_en` shows the map.
- R4: Writing c to the start register makes `start_pulse` equal to exactly bit c, for the one cycle after the write.
- R5: Each command register uses `bus_wdata[7:0]` as the channel number. A value of 64 or more leaves every bitmap and `start_pulse` unchanged.
- R6: A `done_evt` bit sets the channel's done bit and its interrupt-pending bit. `done_irq` is high while any interrupt-pending bit is set. The clear-interrupt command clears one pending bit, and the clear-done command clears one done bit.
- R7: An `err_evt` bit sets the channel's error-pending bit. `err_irq` is high while some channel has both its error-pending bit and its error-interrupt-enable bit set. The set and clear error-interrupt-enable commands change one enable bit, and the clear-error command clears one error-pending bit.
- R8: Error status layout:
  - bit 31: valid
  - bit 15: `err_code[9]` (group priority)
  - bit 14: `err_code[8]` (channel priority)
  - bits 13..8: channel
  - bits 7..0: `err_code[7:0]` (causes)

  It latches on an error while not valid, taking the lowest-numbered erring channel. Later errors leave it unchanged until any write to offset 0x04 clears it.
- R9: Writing a word to an interrupt-pending or error-pending word clears exactly the bits that are one in the written data, so writing all ones clears the word.
- R10: When an event strobe and a software clear hit the same bit in the same cycle, the bit ends up set. When a clear of the error status coincides with a new error, the new error is latched.
- R11: The control word stores only bit 31 (`ctrl_grp_dbg`), bit 3 (`ctrl_rr_group`) and bit 2 (`ctrl_rr_chan`). Its other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| done_evt | input | 64 | Per-channel completion strobes |
| err_evt | input | 64 | Per-channel error strobes |
| err_code | input | 10 | Priority-error and cause bits accompanying err_evt |
| req_en | output | 64 | Request-enable bitmap |
| start_pulse | output | 64 | One-cycle software start per channel |
| ctrl_rr_chan | output | 1 | Round-robin channel arbitration enable |
| ctrl_rr_group | output | 1 | Round-robin group arbitration enable |
| ctrl_grp_dbg | output | 1 | Group/debug enable |
| done_irq | output | 1 | Completion interrupt |
| err_irq | output | 1 | Enabled error interrupt |

## Verification
The bound assertions check the following on every cycle:
- `start_pulse` never has more than one bit set, and it lasts a single cycle.
- Every error strobe leaves the status valid, and a valid status stays frozen without a write to it.
- A completion strobe always raises `done_irq`.
- An out-of-range set-request command never moves `req_en`.
- Every read is answered one cycle later.

The bench scenarios show the rest:
- Exact bit placement in the low and high words.
- The error status field layout and the choice of the lowest channel.
- Write-one-to-clear behaviour on the pending words.
- The gating of `err_irq` by the enable map.
- Set-over-clear priority when an event and a clear collide.

// File: rtl/dmacsr_pkg.sv
package dmacsr_pkg;
  localparam int NCH  = 64;
  localparam int HALF = NCH / 2;
  localparam int CHW  = $clog2(NCH);
  localparam int ECW  = 10;

  localparam logic [7:0] A_CTRL     = 8'h00;
  localparam logic [7:0] A_ERRSTAT  = 8'h04;
  localparam logic [7:0] A_REQ_LO   = 8'h08;
  localparam logic [7:0] A_REQ_HI   = 8'h0C;
  localparam logic [7:0] A_EIE_LO   = 8'h10;
  localparam logic [7:0] A_EIE_HI   = 8'h14;
  localparam logic [7:0] A_INT_LO   = 8'h18;
  localparam logic [7:0] A_INT_HI   = 8'h1C;
  localparam logic [7:0] A_ERR_LO   = 8'h20;
  localparam logic [7:0] A_ERR_HI   = 8'h24;
  localparam logic [7:0] A_DONE_LO  = 8'h28;
  localparam logic [7:0] A_DONE_HI  = 8'h2C;
  localparam logic [7:0] A_SETREQ   = 8'h30;
  localparam logic [7:0] A_CLRREQ   = 8'h34;
  localparam logic [7:0] A_SETEIE   = 8'h38;
  localparam logic [7:0] A_CLREIE   = 8'h3C;
  localparam logic [7:0] A_CLRINT   = 8'h40;
  localparam logic [7:0] A_CLRERR   = 8'h44;
  localparam logic [7:0] A_START    = 8'h48;
  localparam logic [7:0] A_CLRDONE  = 8'h4C;

  localparam logic [31:0] CTRL_MASK = 32'h8000_000C;

  // One-hot of a channel number; numbers outside the channel range decode to nothing.
  function automatic logic [NCH-1:0] chan_decode(input logic [7:0] num);
    logic [NCH-1:0] v;
    v = '0;
    if (int'(num) < NCH) v[num[CHW-1:0]] = 1'b1;
    return v;
  endfunction

  // Lowest-numbered set bit of a strobe vector.
  function automatic logic [CHW-1:0] lowest_chan(input logic [NCH-1:0] v);
    logic [CHW-1:0] idx;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (v[i]) idx = CHW'(i);
    end
    return idx;
  endfunction

  function automatic logic [31:0] pack_errstat(input logic [CHW-1:0] ch,
                                               input logic [ECW-1:0] code);
    return {1'b1, 15'd0, code[9:8], ch, code[7:0]};
  endfunction
endpackage

// File: rtl/dmacsr_bitmap.sv
module dmacsr_bitmap
  import dmacsr_pkg::*;
#(
  parameter bit W1C = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  set_one,
  input  logic [NCH-1:0]  clr_one,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [31:0]     wdata,
  input  logic [NCH-1:0]  evt,
  output logic [NCH-1:0]  bits
);
  logic [NCH-1:0] word_nxt;
  logic [NCH-1:0] nxt;

  generate
    if (W1C) begin : g_w1c
      always_comb begin
        word_nxt = bits;
        if (wr_lo) word_nxt[HALF-1:0]   = bits[HALF-1:0]   & ~wdata[HALF-1:0];
        if (wr_hi) word_nxt[NCH-1:HALF] = bits[NCH-1:HALF] & ~wdata[HALF-1:0];
      end
    end else begin : g_plain
      always_comb begin
        word_nxt = bits;
        if (wr_lo) word_nxt[HALF-1:0]   = wdata[HALF-1:0];
        if (wr_hi) word_nxt[NCH-1:HALF] = wdata[HALF-1:0];
      end
    end
  endgenerate

  // Clear first, then the set sources; a hardware event always survives.
  assign nxt = ((word_nxt & ~clr_one) | set_one) | evt;

  always_ff @(posedge clk) begin
    if (!rst_n) bits <= '0;
    else        bits <= nxt;
  end
endmodule

// File: rtl/dmacsr_errlatch.sv
module dmacsr_errlatch
  import dmacsr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [NCH-1:0]  evt,
  input  logic [ECW-1:0]  code,
  output logic [31:0]     stat
);
  logic held;
  logic capture;

  assign held    = stat[31] && !clr;
  assign capture = (|evt) && !held;

  always_ff @(posedge clk) begin
    if (!rst_n)       stat <= '0;
    else if (capture) stat <= pack_errstat(lowest_chan(evt), code);
    else if (clr)     stat <= '0;
  end
endmodule

// File: rtl/dmacsr_top.sv
module dmacsr_top
  import dmacsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [NCH-1:0]    done_evt,
  input  logic [NCH-1:0]    err_evt,
  input  logic [ECW-1:0]    err_code,
  output logic [NCH-1:0]    req_en,
  output logic [NCH-1:0]    start_pulse,
  output logic              ctrl_rr_chan,
  output logic              ctrl_rr_group,
  output logic              ctrl_grp_dbg,
  output logic              done_irq,
  output logic              err_irq
);
  logic [NCH-1:0] cmd_onehot;
  logic [NCH-1:0] set_req, clr_req, set_eie, clr_eie;
  logic [NCH-1:0] clr_int, clr_err, set_start, clr_done;
  logic [NCH-1:0] eie_map, int_pend, err_pend, done_map;
  logic [31:0]    err_stat;
  logic [31:0]    ctrl_q;
  logic           wr_errstat;

  assign cmd_onehot = chan_decode(bus_wdata[7:0]);

  function automatic logic [NCH-1:0] cmd_for(input logic [7:0] a);
    return (bus_wr && bus_addr == a) ? cmd_onehot : '0;
  endfunction

  function automatic logic wr_at(input logic [7:0] a);
    return bus_wr && bus_addr == a;
  endfunction

  assign set_req   = cmd_for(A_SETREQ);
  assign clr_req   = cmd_for(A_CLRREQ);
  assign set_eie   = cmd_for(A_SETEIE);
  assign clr_eie   = cmd_for(A_CLREIE);
  assign clr_int   = cmd_for(A_CLRINT);
  assign clr_err   = cmd_for(A_CLRERR);
  assign set_start = cmd_for(A_START);
  assign clr_done  = cmd_for(A_CLRDONE);
  assign wr_errstat = wr_at(A_ERRSTAT);

  dmacsr_bitmap #(.W1C(1'b0)) u_req (
    .clk(clk), .rst_n(rst_n), .set_one(set_req), .clr_one(clr_req),
    .wr_lo(wr_at(A_REQ_LO)), .wr_hi(wr_at(A_REQ_HI)), .wdata(bus_wdata),
    .evt('0), .bits(req_en));

  dmacsr_bitmap #(.W1C(1'b0)) u_eie (
    .clk(clk), .rst_n(rst_n), .set_one(set_eie), .clr_one(clr_eie),
    .wr_lo(wr_at(A_EIE_LO)), .wr_hi(wr_at(A_EIE_HI)), .wdata(bus_wdata),
    .evt('0), .bits(eie_map));

  dmacsr_bitmap #(.W1C(1'b1)) u_int (
    .clk(clk), .rst_n(rst_n), .set_one('0), .clr_one(clr_int),
    .wr_lo(wr_at(A_INT_LO)), .wr_hi(wr_at(A_INT_HI)), .wdata(bus_wdata),
    .evt(done_evt), .bits(int_pend));

  dmacsr_bitmap #(.W1C(1'b1)) u_err (
    .clk(clk), .rst_n(rst_n), .set_one('0), .clr_one(clr_err),
    .wr_lo(wr_at(A_ERR_LO)), .wr_hi(wr_at(A_ERR_HI)), .wdata(bus_wdata),
    .evt(err_evt), .bits(err_pend));

  dmacsr_bitmap #(.W1C(1'b0)) u_done (
    .clk(clk), .rst_n(rst_n), .set_one('0), .clr_one(clr_done),
    .wr_lo(1'b0), .wr_hi(1'b0), .wdata(bus_wdata),
    .evt(done_evt), .bits(done_map));

  dmacsr_errlatch u_estat (
    .clk(clk), .rst_n(rst_n), .clr(wr_errstat), .evt(err_evt),
    .code(err_code), .stat(err_stat));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_pulse <= '0;
      ctrl_q      <= '0;
    end else begin
      start_pulse <= set_start;
      if (wr_at(A_CTRL)) ctrl_q <= bus_wdata & CTRL_MASK;
    end
  end

  assign ctrl_grp_dbg  = ctrl_q[31];
  assign ctrl_rr_group = ctrl_q[3];
  assign ctrl_rr_chan  = ctrl_q[2];
  assign done_irq      = |int_pend;
  assign err_irq       = |(err_pend & eie_map);

  logic [31:0] rd_mux;
  always_comb begin
    unique case (bus_addr)
      A_CTRL:    rd_mux = ctrl_q;
      A_ERRSTAT: rd_mux = err_stat;
      A_REQ_LO:  rd_mux = req_en[HALF-1:0];
      A_REQ_HI:  rd_mux = req_en[NCH-1:HALF];
      A_EIE_LO:  rd_mux = eie_map[HALF-1:0];
      A_EIE_HI:  rd_mux = eie_map[NCH-1:HALF];
      A_INT_LO:  rd_mux = int_pend[HALF-1:0];
      A_INT_HI:  rd_mux = int_pend[NCH-1:HALF];
      A_ERR_LO:  rd_mux = err_pend[HALF-1:0];
      A_ERR_HI:  rd_mux = err_pend[NCH-1:HALF];
      A_DONE_LO: rd_mux = done_map[HALF-1:0];
      A_DONE_HI: rd_mux = done_map[NCH-1:HALF];
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/dmacsr_checker.sv
module dmacsr_checker
  import dmacsr_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [7:0]      bus_addr,
  input logic [31:0]     bus_wdata,
  input logic            bus_rvalid,
  input logic [NCH-1:0]  done_evt,
  input logic [NCH-1:0]  err_evt,
  input logic [NCH-1:0]  req_en,
  input logic [NCH-1:0]  start_pulse,
  input logic            done_irq,
  input logic [31:0]     err_stat
);
  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  assert_start_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_pulse));

  assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|start_pulse) && !(bus_wr && bus_addr == A_START)) |=> (start_pulse == '0));

  assert_range_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SETREQ && bus_wdata[7:6] != 2'b00) |=> $stable(req_en));

  assert_done_raises_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_evt) |=> done_irq);

  assert_err_latches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_evt) |=> err_stat[31]);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_stat[31] && !(bus_wr && bus_addr == A_ERRSTAT)) |=> $stable(err_stat));
endmodule

bind dmacsr_top dmacsr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
  .done_evt(done_evt), .err_evt(err_evt), .req_en(req_en),
  .start_pulse(start_pulse), .done_irq(done_irq), .err_stat(err_stat));

// File: tb/dmacsr_top_test.sv
module dmacsr_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [63:0] done_evt = '0, err_evt = '0;
  logic [9:0]  err_code = '0;
  logic [63:0] req_en, start_pulse;
  logic        ctrl_rr_chan, ctrl_rr_group, ctrl_grp_dbg, done_irq, err_irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  dmacsr_top uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .done_evt(done_evt), .err_evt(err_evt),
    .err_code(err_code), .req_en(req_en), .start_pulse(start_pulse),
    .ctrl_rr_chan(ctrl_rr_chan), .ctrl_rr_group(ctrl_rr_group),
    .ctrl_grp_dbg(ctrl_grp_dbg), .done_irq(done_irq), .err_irq(err_irq));

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: compares each returned read against the scoreboard.
  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: unexpected read data %h expected none", bus_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(64'(bus_rdata), 64'(e), t);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic [63:0] d, input logic [63:0] e, input logic [9:0] c);
    @(negedge clk); done_evt = d; err_evt = e; err_code = c;
    @(negedge clk); done_evt = '0; err_evt = '0; err_code = '0;
  endtask

  function automatic logic [31:0] estat(input int ch, input logic [9:0] c);
    return 32'h8000_0000 | (32'(c[9]) << 15) | (32'(c[8]) << 14) | (32'(ch) << 8) | 32'(c[7:0]);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check({done_irq, err_irq, bus_rvalid}, 0, "R1 irq/rvalid");
    check(req_en, 0, "R1 req_en");
    rd(8'h00, 0, "R1 ctrl");
    rd(8'h04, 0, "R1 errstat");
    rd(8'h1C, 0, "R1 int_hi");
    rd(8'h2C, 0, "R1 done_hi");
    rd(8'h7C, 0, "R2 unmapped");

    // R3 set/clear request enables
    wr(8'h30, 5); wr(8'h30, 40); wr(8'h30, 63);
    check(req_en, (64'd1 << 5) | (64'd1 << 40) | (64'd1 << 63), "R3 req_en map");
    rd(8'h08, 32'h20, "R3 req lo");
    rd(8'h0C, 32'h8000_0100, "R3 req hi");
    wr(8'h34, 5);
    rd(8'h08, 0, "R3 clr req");
    rd(8'h30, 0, "R2 cmd reads zero");
    wr(8'h08, 32'hA5A5_0000);
    check(req_en[31:0], 64'hA5A5_0000, "R3 word write");

    // R5 out-of-range numbers ignored
    wr(8'h30, 64); wr(8'h30, 8'hC5); wr(8'h34, 8'h48);
    rd(8'h08, 32'hA5A5_0000, "R5 req lo unchanged");
    rd(8'h0C, 32'h8000_0100, "R5 req hi unchanged");

    // R11 control mask
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h8000_000C, "R11 ctrl mask");
    check({ctrl_grp_dbg, ctrl_rr_group, ctrl_rr_chan}, 3'b111, "R11 ctrl outputs");
    wr(8'h00, 32'h0000_0004);
    check({ctrl_grp_dbg, ctrl_rr_group, ctrl_rr_chan}, 3'b001, "R11 rr_chan only");

    // R4 start pulse
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h48; bus_wdata = 7;
    @(negedge clk); bus_wr = 1'b0;
    check(start_pulse, 64'd1 << 7, "R4 start pulse");
    @(negedge clk);
    check(start_pulse, 0, "R4 start one cycle");
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h48; bus_wdata = 99;
    @(negedge clk); bus_wr = 1'b0;
    check(start_pulse, 0, "R5 start out of range");

    // R6 completion events
    pulse((64'd1 << 3) | (64'd1 << 35), 0, 0);
    check(done_irq, 1, "R6 done_irq");
    rd(8'h18, 32'h8, "R6 int lo");
    rd(8'h1C, 32'h8, "R6 int hi");
    rd(8'h28, 32'h8, "R6 done lo");
    wr(8'h40, 3);
    rd(8'h18, 0, "R6 clr int");
    wr(8'h40, 8'h43);
    rd(8'h1C, 32'h8, "R5 clr int out of range");
    wr(8'h4C, 3);
    rd(8'h28, 0, "R6 clr done");
    rd(8'h2C, 32'h8, "R6 done hi kept");
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, 0, "R9 int W1C all");
    check(done_irq, 0, "R6 done_irq low");

    // R9 partial W1C
    pulse(64'h0000_00F0_0000_000F, 0, 0);
    wr(8'h18, 32'h5);
    rd(8'h18, 32'hA, "R9 partial W1C");
    wr(8'h18, 32'hFFFF_FFFF); wr(8'h1C, 32'hFFFF_FFFF);

    // R7/R8 errors
    pulse(0, 64'd1 << 10, 10'b10_0010_0001);
    rd(8'h04, estat(10, 10'b10_0010_0001), "R8 errstat first");
    check(err_irq, 0, "R7 err_irq masked");
    wr(8'h38, 10);
    check(err_irq, 1, "R7 err_irq enabled");
    pulse(0, 64'd1 << 50, 10'b01_1000_0000);
    rd(8'h04, estat(10, 10'b10_0010_0001), "R8 sticky");
    rd(8'h24, 32'h4_0000, "R7 err hi");
    wr(8'h44, 10);
    check(err_irq, 0, "R7 clr err");
    wr(8'h38, 50);
    check(err_irq, 1, "R7 eie hi");
    wr(8'h3C, 50);
    check(err_irq, 0, "R7 clr eie");
    wr(8'h04, 0);
    rd(8'h04, 0, "R8 clear");
    pulse(0, (64'd1 << 50) | (64'd1 << 12), 10'b00_0100_0000);
    rd(8'h04, estat(12, 10'b00_0100_0000), "R8 lowest channel");
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h24, 0, "R9 err W1C");

    // R10 collisions
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h40; bus_wdata = 2; done_evt = 64'd1 << 2;
    @(negedge clk); bus_wr = 1'b0; done_evt = '0;
    rd(8'h18, 32'h4, "R10 event beats clear");
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 0;
    err_evt = 64'd1 << 33; err_code = 10'h003;
    @(negedge clk); bus_wr = 1'b0; err_evt = '0; err_code = '0;
    rd(8'h04, estat(33, 10'h003), "R10 new error beats clear");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2: actual %0d pending reads expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule